// File: doc/BRIEF.md
# PCI Configuration Cycle Decoder

This block sits beside the bus interface of a two-port PCI bridge. It watches the address phase of every transaction. When the command is a configuration read or a configuration write, it decides whether the cycle is Type 0 or Type 1, using the two lowest address bits. It also splits the address into its register, function, device and bus number fields.

A Type 0 cycle can target the bridge's own configuration space. The block claims such a cycle only when all of these hold:
- the cycle arrives on the primary side,
- IDSEL is high,
- the function number is one the bridge implements.

While it claims a cycle, it drives an active-low DEVSEL indication.

A Type 1 cycle seen on the primary side is checked against the programmed secondary and subordinate bus numbers. The block flags the cycle for forwarding when the bus number falls in that range. When the target is the secondary bus itself, it also flags that the cycle must be converted to Type 0.

All results are registered on the clock edge that closes the address phase. They are held until the bus returns to idle, or until reset.

Top module: `cfg_cycle_decoder`

## Requirements
- R1: A configuration command (C/BE code 1010b read or 1011b write) whose address bits [1:0] are 00b sets `is_type0`=1 and `is_type1`=0 on the edge closing the address phase.
- R2: A configuration command with address bits [1:0] = 01b sets `is_type1`=1 and `is_type0`=0. Codes 10b and 11b set neither flag and give no claim and no forward.
- R3: For a configuration cycle, the block outputs four fields:
  - `reg_idx` = address [7:2]
  - `func_num` = address [10:8]
  - `dev_num` = address [15:11]
  - `bus_num` = address [23:16]
- R4: `claim` is 1 only for a Type 0 cycle on the primary side (`on_secondary`=0) with `idsel` high in the address phase.
- R5: A Type 0 cycle with `on_secondary`=1 is never claimed, whatever the state of `idsel`.
- R6: With the default single-function setting (NUM_FUNCS=1), the function number has no effect on `claim`.
- R7: `devsel_n` is low exactly while `claim` is held and is high otherwise.
- R8: A Type 1 cycle on the primary side sets `fwd` when `sec_bus` <= bus number <= `sub_bus`. It also sets `to_type0` when the bus number equals `sec_bus`. A Type 1 cycle on the secondary side sets neither flag.
- R9: An address phase whose command is not a configuration command leaves `cfg_valid` and all decode outputs at 0.
- R10: Decode outputs are held unchanged until a cycle in which `frame_n` and `irdy_n` are both high. They return to 0 on that edge.
- R11: When `rst_n` is low at a clock edge, every output returns to its idle value: all flags and fields 0, `devsel_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe | input | 4 | Command field during the address phase |
| addr | input | 24 | Low 24 bits of the address/data bus |
| idsel | input | 1 | Configuration select line |
| on_secondary | input | 1 | 1 when the cycle arrives on the secondary port |
| sec_bus | input | 8 | Programmed secondary bus number |
| sub_bus | input | 8 | Programmed subordinate bus number |
| cfg_valid | output | 1 | A configuration cycle was decoded and is held |
| is_type0 | output | 1 | Held cycle is Type 0 |
| is_type1 | output | 1 | Held cycle is Type 1 |
| reg_idx | output | 6 | DWORD register index |
| func_num | output | 3 | Function number |
| dev_num | output | 5 | Device number |
| bus_num | output | 8 | Target bus number |
| claim | output | 1 | Bridge claims the cycle for its own space |
| devsel_n | output | 1 | Device select indication, active low |
| fwd | output | 1 | Type 1 cycle should be forwarded downstream |
| to_type0 | output | 1 | Forwarded cycle targets the secondary bus directly |

## Verification
The hardest case to reach is the hold window. A decode must stay stable after `frame_n` has already been released while `irdy_n` is still low. It must clear only when both signals go high. The stimulus reaches this case by driving a single-data-phase transaction that releases the two signals on separate cycles, then checking the outputs in the cycle between them.

The boundaries of the forwarding range need a similar approach. Bus numbers one below `sec_bus`, equal to `sec_bus`, equal to `sub_bus`, and one above `sub_bus` are each driven as separate Type 1 cycles.

// File: rtl/cfg_dec_pkg.sv
// Package: shared command codes, format encoding and decision bundle
// for the configuration cycle decoder.
package cfg_dec_pkg;

    // Bus command codes that select configuration space.
    localparam logic [3:0] CMD_CFG_READ  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;

    // Encoding carried in address bits [1:0] of a configuration cycle.
    typedef enum logic [1:0] {
        FMT_LOCAL  = 2'b00,
        FMT_REMOTE = 2'b01,
        FMT_RSV_A  = 2'b10,
        FMT_RSV_B  = 2'b11
    } cfg_fmt_e;

    // Per-cycle decisions produced by the claim logic.
    typedef struct packed {
        logic cfg;
        logic type0;
        logic type1;
        logic claim;
        logic fwd;
        logic to_type0;
    } cfg_dec_t;

endpackage

// File: rtl/cfg_phase_tracker.sv
// Module: cfg_phase_tracker
// Finds the address phase (first cycle with frame_n low after it was high)
// and reports bus idle (frame_n and irdy_n both high).
// Assumes frame_n and irdy_n are synchronous to clk.
module cfg_phase_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic addr_phase,
    output logic bus_idle
);

    logic frame_q;

    // Remember the previous frame_n level to detect its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= 1'b1;
        else        frame_q <= frame_n;
    end

    // Address phase is the first cycle of an asserted frame.
    always_comb addr_phase = frame_q && !frame_n;

    // Idle when neither framing nor initiator-ready is asserted.
    always_comb bus_idle = frame_n && irdy_n;

    AST_ADDR_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |-> !bus_idle);  // R10

endmodule

// File: rtl/cfg_field_extract.sv
// Module: cfg_field_extract
// Slices the address word into format, register, function, device and
// bus fields. Field positions are derived from the widths: register
// field starts at bit 2, each following field sits directly above.
module cfg_field_extract #(
    parameter int REG_W  = 6,
    parameter int FUNC_W = 3,
    parameter int DEV_W  = 5,
    parameter int BUS_W  = 8,
    localparam int REG_LSB  = 2,
    localparam int FUNC_LSB = REG_LSB + REG_W,
    localparam int DEV_LSB  = FUNC_LSB + FUNC_W,
    localparam int BUS_LSB  = DEV_LSB + DEV_W,
    localparam int ADDR_W   = BUS_LSB + BUS_W
) (
    input  logic [ADDR_W-1:0]   addr,
    output cfg_dec_pkg::cfg_fmt_e fmt,
    output logic [REG_W-1:0]    reg_f,
    output logic [FUNC_W-1:0]   func_f,
    output logic [DEV_W-1:0]    dev_f,
    output logic [BUS_W-1:0]    bus_f
);

    // Split the address into its fields.
    always_comb begin
        fmt    = cfg_dec_pkg::cfg_fmt_e'(addr[1:0]);
        reg_f  = addr[FUNC_LSB-1:REG_LSB];
        func_f = addr[DEV_LSB-1:FUNC_LSB];
        dev_f  = addr[BUS_LSB-1:DEV_LSB];
        bus_f  = addr[ADDR_W-1:BUS_LSB];
    end

endmodule

// File: rtl/cfg_claim_logic.sv
// Module: cfg_claim_logic
// Combinational decisions for one address phase: configuration command,
// format, self-claim and Type 1 forwarding. NUM_FUNCS <= 1 means a
// single-function device, so the function number is not decoded.
module cfg_claim_logic #(
    parameter int FUNC_W    = 3,
    parameter int BUS_W     = 8,
    parameter int NUM_FUNCS = 1
) (
    input  logic [3:0]            cbe,
    input  cfg_dec_pkg::cfg_fmt_e fmt,
    input  logic [FUNC_W-1:0]     func_f,
    input  logic [BUS_W-1:0]      bus_f,
    input  logic                  idsel,
    input  logic                  on_secondary,
    input  logic [BUS_W-1:0]      sec_bus,
    input  logic [BUS_W-1:0]      sub_bus,
    output cfg_dec_pkg::cfg_dec_t dec
);
    import cfg_dec_pkg::*;

    logic func_ok;

    // Pick the function filter according to the function count.
    generate
        if (NUM_FUNCS <= 1) begin : g_single
            always_comb func_ok = 1'b1;
        end else begin : g_multi
            always_comb func_ok = ({1'b0, func_f} < (FUNC_W+1)'(NUM_FUNCS));
        end
    endgenerate

    // Derive format flags, self-claim and forwarding decisions.
    always_comb begin
        dec          = '0;
        dec.cfg      = (cbe == CMD_CFG_READ) || (cbe == CMD_CFG_WRITE);
        dec.type0    = dec.cfg && (fmt == FMT_LOCAL);
        dec.type1    = dec.cfg && (fmt == FMT_REMOTE);
        dec.claim    = dec.type0 && idsel && !on_secondary && func_ok;
        dec.fwd      = dec.type1 && !on_secondary &&
                       (bus_f >= sec_bus) && (bus_f <= sub_bus);
        dec.to_type0 = dec.fwd && (bus_f == sec_bus);
    end

    AST_CLAIM_NEEDS_IDSEL: assert final (!dec.claim || idsel);                 // R4
    AST_NO_SEC_CLAIM:      assert final (!(dec.claim && on_secondary));        // R5
    AST_RSV_FMT_INERT:     assert final (!((fmt == FMT_RSV_A || fmt == FMT_RSV_B)
                                            && (dec.claim || dec.fwd)));        // R2

endmodule

// File: rtl/cfg_cycle_decoder.sv
// Module: cfg_cycle_decoder (top)
// Decodes the address phase of configuration cycles seen by a two-port
// bridge and holds the result until the bus goes idle. Assumes addr and
// cbe are valid in the address phase (first cycle of frame_n low).
module cfg_cycle_decoder #(
    parameter int REG_W     = 6,
    parameter int FUNC_W    = 3,
    parameter int DEV_W     = 5,
    parameter int BUS_W     = 8,
    parameter int NUM_FUNCS = 1,
    localparam int ADDR_W   = 2 + REG_W + FUNC_W + DEV_W + BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [3:0]        cbe,
    input  logic [ADDR_W-1:0] addr,
    input  logic              idsel,
    input  logic              on_secondary,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              cfg_valid,
    output logic              is_type0,
    output logic              is_type1,
    output logic [REG_W-1:0]  reg_idx,
    output logic [FUNC_W-1:0] func_num,
    output logic [DEV_W-1:0]  dev_num,
    output logic [BUS_W-1:0]  bus_num,
    output logic              claim,
    output logic              devsel_n,
    output logic              fwd,
    output logic              to_type0
);
    import cfg_dec_pkg::*;

    logic                addr_phase;
    logic                bus_idle;
    cfg_fmt_e            fmt;
    logic [REG_W-1:0]    reg_f;
    logic [FUNC_W-1:0]   func_f;
    logic [DEV_W-1:0]    dev_f;
    logic [BUS_W-1:0]    bus_f;
    cfg_dec_t            dec;
    cfg_dec_t            dec_q;

    cfg_phase_tracker u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .addr_phase (addr_phase),
        .bus_idle   (bus_idle)
    );

    cfg_field_extract #(
        .REG_W (REG_W), .FUNC_W (FUNC_W), .DEV_W (DEV_W), .BUS_W (BUS_W)
    ) u_fields (
        .addr   (addr),
        .fmt    (fmt),
        .reg_f  (reg_f),
        .func_f (func_f),
        .dev_f  (dev_f),
        .bus_f  (bus_f)
    );

    cfg_claim_logic #(
        .FUNC_W (FUNC_W), .BUS_W (BUS_W), .NUM_FUNCS (NUM_FUNCS)
    ) u_claim (
        .cbe          (cbe),
        .fmt          (fmt),
        .func_f       (func_f),
        .bus_f        (bus_f),
        .idsel        (idsel),
        .on_secondary (on_secondary),
        .sec_bus      (sec_bus),
        .sub_bus      (sub_bus),
        .dec          (dec)
    );

    // Capture decisions at the address phase; clear on idle or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || (bus_idle && !addr_phase)) begin
            dec_q <= '0;
        end else if (addr_phase) begin
            dec_q <= dec;
        end
    end

    // Capture fields of configuration cycles only; clear on idle or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || (bus_idle && !addr_phase) || (addr_phase && !dec.cfg)) begin
            reg_idx  <= '0;
            func_num <= '0;
            dev_num  <= '0;
            bus_num  <= '0;
        end else if (addr_phase) begin
            reg_idx  <= reg_f;
            func_num <= func_f;
            dev_num  <= dev_f;
            bus_num  <= bus_f;
        end
    end

    // Drive the held decisions onto the output ports.
    always_comb begin
        cfg_valid = dec_q.cfg;
        is_type0  = dec_q.type0;
        is_type1  = dec_q.type1;
        claim     = dec_q.claim;
        fwd       = dec_q.fwd;
        to_type0  = dec_q.to_type0;
        devsel_n  = !dec_q.claim;
    end

    AST_TYPE_EXCL:     assert property (@(posedge clk) disable iff (!rst_n)
        !(is_type0 && is_type1));                                       // R1
    AST_CLAIM_VALID:   assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (cfg_valid && is_type0));                             // R4
    AST_FWD_RANGE:     assert property (@(posedge clk) disable iff (!rst_n)
        fwd |-> (is_type1 && bus_num >= sec_bus && bus_num <= sub_bus)); // R8
    AST_TOT0_FWD:      assert property (@(posedge clk) disable iff (!rst_n)
        to_type0 |-> fwd);                                              // R8
    AST_HOLD:          assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !addr_phase && !bus_idle) |=>
            ($stable(bus_num) && $stable(reg_idx) && $stable(claim)));  // R10
    AST_IDLE_CLEAR:    assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && !addr_phase) |=> (!cfg_valid && devsel_n));        // R10
    AST_NONCFG_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && !dec.cfg) |=> (!cfg_valid && bus_num == '0));    // R9

endmodule

// File: tb/tb_cfg_cycle_decoder.sv
// Directed bench for cfg_cycle_decoder: one task per scenario.
module tb_cfg_cycle_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe = 4'h0;
    logic [23:0] addr = '0;
    logic        idsel = 1'b0;
    logic        on_secondary = 1'b0;
    logic [7:0]  sec_bus = 8'd3;
    logic [7:0]  sub_bus = 8'd7;
    logic        cfg_valid, is_type0, is_type1, claim, devsel_n, fwd, to_type0;
    logic [5:0]  reg_idx;
    logic [2:0]  func_num;
    logic [4:0]  dev_num;
    logic [7:0]  bus_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    cfg_cycle_decoder dut (
        .clk (clk), .rst_n (rst_n), .frame_n (frame_n), .irdy_n (irdy_n),
        .cbe (cbe), .addr (addr), .idsel (idsel), .on_secondary (on_secondary),
        .sec_bus (sec_bus), .sub_bus (sub_bus), .cfg_valid (cfg_valid),
        .is_type0 (is_type0), .is_type1 (is_type1), .reg_idx (reg_idx),
        .func_num (func_num), .dev_num (dev_num), .bus_num (bus_num),
        .claim (claim), .devsel_n (devsel_n), .fwd (fwd), .to_type0 (to_type0)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " cfg_valid"}, 32'(cfg_valid), 0);
        chk({tag, " type0"},     32'(is_type0), 0);
        chk({tag, " type1"},     32'(is_type1), 0);
        chk({tag, " claim"},     32'(claim), 0);
        chk({tag, " devsel_n"},  32'(devsel_n), 1);
        chk({tag, " fwd"},       32'(fwd), 0);
        chk({tag, " to_type0"},  32'(to_type0), 0);
        chk({tag, " fields"},    {6'd0, reg_idx, func_num, dev_num, bus_num}, 0);
    endtask

    // Drive one single-data-phase transaction, check decode, hold and clear.
    task automatic exercise(input string tag, input logic [3:0] c, input logic [23:0] a,
                            input logic ids, input logic sec);
        logic cfg, t0, t1, cl, fw, tt;
        cfg = (c == 4'b1010) || (c == 4'b1011);
        t0  = cfg && (a[1:0] == 2'b00);
        t1  = cfg && (a[1:0] == 2'b01);
        cl  = t0 && ids && !sec;
        fw  = t1 && !sec && (a[23:16] >= sec_bus) && (a[23:16] <= sub_bus);
        tt  = fw && (a[23:16] == sec_bus);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cbe = c; addr = a; idsel = ids; on_secondary = sec;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe = 4'h0; addr = 24'hFFFFFF; idsel = 1'b0;
        for (int k = 0; k < 2; k++) begin
            string ph;
            ph = (k == 0) ? {tag, " decode"} : {tag, " held R10"};
            chk({ph, " cfg R9"},   32'(cfg_valid), 32'(cfg));
            chk({ph, " type0 R1"}, 32'(is_type0), 32'(t0));
            chk({ph, " type1 R2"}, 32'(is_type1), 32'(t1));
            chk({ph, " reg R3"},   32'(reg_idx),  cfg ? 32'(a[7:2])   : 0);
            chk({ph, " func R3"},  32'(func_num), cfg ? 32'(a[10:8])  : 0);
            chk({ph, " dev R3"},   32'(dev_num),  cfg ? 32'(a[15:11]) : 0);
            chk({ph, " bus R3"},   32'(bus_num),  cfg ? 32'(a[23:16]) : 0);
            chk({ph, " claim R4"}, 32'(claim), 32'(cl));
            chk({ph, " devsel R7"}, 32'(devsel_n), 32'(!cl));
            chk({ph, " fwd R8"},   32'(fwd), 32'(fw));
            chk({ph, " tot0 R8"},  32'(to_type0), 32'(tt));
            if (k == 0) @(negedge clk);
        end
        irdy_n = 1'b1;
        @(negedge clk);
        chk_idle({tag, " cleared R10"});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("reset R11");
        rst_n = 1'b1;
    endtask

    task automatic t_type0;
        exercise("t0 primary claim R4", 4'b1010, {8'h00, 5'd9, 3'd5, 6'h15, 2'b00}, 1'b1, 1'b0);
        exercise("t0 write claim R4",   4'b1011, {8'hA5, 5'd31, 3'd0, 6'h3F, 2'b00}, 1'b1, 1'b0);
        exercise("t0 no idsel R4",      4'b1010, {8'h00, 5'd1, 3'd0, 6'h01, 2'b00}, 1'b0, 1'b0);
    endtask

    task automatic t_secondary;
        exercise("t0 secondary R5",      4'b1010, {8'h00, 5'd2, 3'd0, 6'h04, 2'b00}, 1'b1, 1'b1);
        exercise("t1 secondary R8",      4'b1010, {8'd5, 5'd2, 3'd0, 6'h04, 2'b01}, 1'b0, 1'b1);
    endtask

    task automatic t_single_func;
        exercise("func7 ignored R6", 4'b1010, {8'h00, 5'd0, 3'd7, 6'h02, 2'b00}, 1'b1, 1'b0);
        exercise("func3 ignored R6", 4'b1011, {8'h00, 5'd0, 3'd3, 6'h10, 2'b00}, 1'b1, 1'b0);
    endtask

    task automatic t_forward;
        exercise("bus below R8", 4'b1010, {8'd2, 5'd4, 3'd1, 6'h08, 2'b01}, 1'b0, 1'b0);
        exercise("bus = sec R8", 4'b1010, {8'd3, 5'd4, 3'd1, 6'h08, 2'b01}, 1'b0, 1'b0);
        exercise("bus mid R8",   4'b1011, {8'd5, 5'd4, 3'd1, 6'h08, 2'b01}, 1'b0, 1'b0);
        exercise("bus = sub R8", 4'b1010, {8'd7, 5'd4, 3'd1, 6'h08, 2'b01}, 1'b0, 1'b0);
        exercise("bus above R8", 4'b1010, {8'd8, 5'd4, 3'd1, 6'h08, 2'b01}, 1'b0, 1'b0);
    endtask

    task automatic t_invalid;
        exercise("fmt 10b R2", 4'b1010, {8'd5, 5'd4, 3'd1, 6'h08, 2'b10}, 1'b1, 1'b0);
        exercise("fmt 11b R2", 4'b1011, {8'd3, 5'd4, 3'd1, 6'h08, 2'b11}, 1'b1, 1'b0);
    endtask

    task automatic t_noncfg;
        exercise("mem read R9", 4'b0110, {8'd5, 5'd4, 3'd1, 6'h08, 2'b00}, 1'b1, 1'b0);
        exercise("io write R9", 4'b0011, {8'd3, 5'd4, 3'd1, 6'h08, 2'b01}, 1'b1, 1'b0);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        frame_n = 1'b0; cbe = 4'b1010; addr = {8'h00, 5'd1, 3'd0, 6'h01, 2'b00};
        idsel = 1'b1; on_secondary = 1'b0;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0;
        chk("mid claim before reset R4", 32'(claim), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("mid reset R11");
        rst_n = 1'b1; irdy_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset;
        t_type0;
        t_secondary;
        t_single_func;
        t_forward;
        t_invalid;
        t_noncfg;
        t_reset_mid;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule